// File: doc/BRIEF.md
# Frame Size Statistics Counter Bank

This block keeps per-direction traffic statistics for an Ethernet-style MAC. Whenever a frame finishes, the MAC pulses a done strobe together with a direction flag (transmit or receive) and the frame length in bytes. On the next clock edge the block bumps several 32-bit counters belonging to that direction at once: the packet count, the good-frame count, the octet total, the good-octet total, and exactly one size bucket. The size bucket is either a fragment counter for runt frames or one of seven length bins with uneven boundaries.

All counters form one word-addressed register window. Software can read any counter and can also preset any counter, for example to clear it or to load a value near the wrap point. Window words that no frame event ever touches are still plain read/write storage. They hold error-type statistics that other logic does not update here.

Top module: `stat_counter_bank`

## Requirements
- R1: After a synchronous active-low reset every counter word reads 0.
- R2: Each completed frame adds 1 to its direction's packet counter (transmit word 1, receive word 33) and to its good-frame counter (transmit word 19, receive word 51).
- R3: Each completed frame adds its length to its direction's octet counter (transmit word 17, receive word 49) and to its good-octet counter (transmit word 29, receive word 56).
- R4: A frame shorter than 64 bytes adds 1 to the fragment counter (transmit word 7, receive word 39) and to no length bin.
- R5: A frame of 64 bytes or more adds 1 to exactly one bin, at word base+10 for exactly 64, base+11 for 65 to 127, base+12 for 128 to 255, base+13 for 256 to 511, base+14 for 512 to 1023, base+15 for 1024 to 2047 and base+16 for 2048 and above, where base is 0 for transmit and 32 for receive.
- R6: A frame changes no word except those named in R2 to R5 for its own direction. Words 0, 2 to 6, 8, 9, 18, 20 to 28, 30 to 32, 34 to 38, 40, 41, 50 and 52 to 55 are never changed by frames.
- R7: Counter word n (0 to 56) is at byte address 0x200 + 4n, with the two low address bits ignored. Reads are combinational. A read outside 0x200 to 0x2E3 returns 0, and a write there changes no word.
- R8: When a software write and a frame update hit the same word in one cycle, the word takes the written value. The frame's other words still update.
- R9: Counters wrap modulo 2^32. Frame length is a 16-bit input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_done | input | 1 | One-cycle pulse marking a completed frame |
| fr_dir | input | 1 | Frame direction: 0 transmit, 1 receive |
| fr_len | input | 16 | Frame length in bytes |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The bench builds the block with its default parameters: 32-bit counters, 16-bit length and a 10-bit address. With these values every frame length from 0 to 2100 can be swept in both directions, so every bin boundary is crossed. The bench also reads back all 57 window words after each frame, which shows that no unrelated word moves. Presetting counters just below 2^32 puts wrap of both the unit and the length adders within a single frame. Driving a write and a frame in the same cycle covers the write-priority rule.

// File: rtl/stat_pkg.sv
// Shared constants and word-layout helpers for the statistics counter bank.
// Assumes a 57-word window; receive words mirror transmit words at +32,
// except the good-octet word, which sits at a fixed index on each side.
package stat_pkg;

    localparam int NUM_WORDS   = 57;
    localparam int SIDE_STRIDE = 32;
    localparam int OFS_PKT     = 1;
    localparam int OFS_FRAG    = 7;
    localparam int OFS_BIN0    = 10;
    localparam int NUM_BINS    = 7;
    localparam int OFS_OCT     = 17;
    localparam int OFS_GOOD    = 19;
    localparam int TX_GOCT     = 29;
    localparam int RX_GOCT     = 56;
    localparam int BIN_W       = $clog2(NUM_BINS);

    typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

    // Does word w receive a +1 from a frame on the side starting at base?
    function automatic logic unit_hit(input int w, input int base,
                                      input logic frag, input logic [BIN_W-1:0] bin);
        int rel;
        rel = w - base;
        return (rel == OFS_PKT) || (rel == OFS_GOOD) ||
               (frag && rel == OFS_FRAG) ||
               (!frag && rel >= OFS_BIN0 && rel < OFS_BIN0 + NUM_BINS &&
                int'(bin) == rel - OFS_BIN0);
    endfunction

    // Does word w receive +length from a frame on the given side?
    function automatic logic len_hit(input int w, input logic rx);
        if (rx) return (w == SIDE_STRIDE + OFS_OCT) || (w == RX_GOCT);
        else    return (w == OFS_OCT) || (w == TX_GOCT);
    endfunction

endpackage

// File: rtl/stat_bin_sel.sv
// Length classifier: flags runt frames and picks the histogram bin.
// Assumes LEN_W >= 12 so the largest threshold (2048) is representable.
module stat_bin_sel
    import stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] len,
    output logic             is_frag,
    output logic [BIN_W-1:0] bin
);
    localparam int NUM_STEPS = NUM_BINS - 2;  // power-of-two thresholds above 64

    logic [NUM_STEPS-1:0] above;

    // One comparator per power-of-two boundary 128, 256, ... 2048.
    genvar k;
    generate
        for (k = 0; k < NUM_STEPS; k++) begin : g_thr
            assign above[k] = ({{(32-LEN_W){1'b0}}, len} >= (32'd128 << k));
        end
    endgenerate

    // Runt flag and bin index: exact 64 is bin 0, else 1 + boundaries passed.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int j = 0; j < NUM_STEPS; j++) cnt += int'(above[j]);
        is_frag = ({{(32-LEN_W){1'b0}}, len} < 32'd64);
        if ({{(32-LEN_W){1'b0}}, len} == 32'd64) bin = '0;
        else                                     bin = BIN_W'(cnt + 1);
    end

endmodule

// File: rtl/stat_decode.sv
// Turns a frame-done event into per-word increment strobes: one vector
// for +1 updates and one for +length updates. Assumes fr_done lasts one cycle.
module stat_decode
    import stat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fr_done,
    input  logic                 fr_dir,
    input  logic [LEN_W-1:0]     fr_len,
    output logic [NUM_WORDS-1:0] inc_one,
    output logic [NUM_WORDS-1:0] inc_len
);
    logic             is_frag;
    logic [BIN_W-1:0] bin;

    stat_bin_sel #(.LEN_W(LEN_W)) u_bin (
        .len    (fr_len),
        .is_frag(is_frag),
        .bin    (bin)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_WORDS; i++) begin : g_word
            // Select this word's strobes for the side named by fr_dir.
            always_comb begin
                if (fr_dir == DIR_RX) begin
                    inc_one[i] = fr_done && unit_hit(i, SIDE_STRIDE, is_frag, bin);
                    inc_len[i] = fr_done && len_hit(i, 1'b1);
                end else begin
                    inc_one[i] = fr_done && unit_hit(i, 0, is_frag, bin);
                    inc_len[i] = fr_done && len_hit(i, 1'b0);
                end
            end
        end
    endgenerate

    // R2 R4 R5: a frame raises packet, good-frame and exactly one size word.
    a_r2_three_unit_hits: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |-> ($countones(inc_one) == 3));
    // R3: a frame raises exactly the two octet words.
    a_r3_two_len_hits: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done |-> ($countones(inc_len) == 2));
    // R6: no strobe without a frame.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_done |-> (inc_one == '0 && inc_len == '0));

endmodule

// File: rtl/stat_word.sv
// One counter word: software write first, then +length, then +1.
// Assumes inc_one and inc_len are never both set for the same word.
module stat_word #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             inc_one,
    input  logic             inc_len,
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] q
);
    // Counter update with write priority and modulo-2^CNT_W wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (wr)      q <= wdata;
        else if (inc_len) q <= q + CNT_W'(len);
        else if (inc_one) q <= q + CNT_W'(1);
    end

    // R8: a write always lands, even against a frame update.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(wdata)));
    // R9: a unit step wraps modulo 2^CNT_W.
    a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && inc_one && !inc_len) |=> (q == $past(q) + CNT_W'(1)));
    // R3: the length is added in full.
    a_r3_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && inc_len) |=> (q == $past(q) + CNT_W'($past(len))));
    // R6: without a strobe the word holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !inc_one && !inc_len) |=> $stable(q));

endmodule

// File: rtl/stat_counter_bank.sv
// Statistics counter bank: frame events update per-direction counters,
// and a register window gives software read and preset access to all words.
// Assumes the window base is 256-byte aligned within the ADDR_W space.
module stat_counter_bank
    import stat_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int LEN_W    = 16,
    parameter int ADDR_W   = 10,
    parameter int WIN_BASE = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_done,
    input  logic              fr_dir,
    input  logic [LEN_W-1:0]  fr_len,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);

    logic [NUM_WORDS-1:0] inc_one;
    logic [NUM_WORDS-1:0] inc_len;
    logic [NUM_WORDS-1:0] wr_sel;
    logic [CNT_W-1:0]     words [NUM_WORDS];
    logic [ADDR_W-1:0]    word_idx;
    logic                 in_win;

    stat_decode #(.LEN_W(LEN_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .fr_done(fr_done),
        .fr_dir (fr_dir),
        .fr_len (fr_len),
        .inc_one(inc_one),
        .inc_len(inc_len)
    );

    // Window decode: word index from the byte offset, low bits dropped.
    always_comb begin
        word_idx = (reg_addr - BASE_A) >> 2;
        in_win   = (reg_addr >= BASE_A) && (word_idx < ADDR_W'(NUM_WORDS));
    end

    genvar i;
    generate
        for (i = 0; i < NUM_WORDS; i++) begin : g_cnt
            assign wr_sel[i] = reg_wr && in_win && (word_idx == ADDR_W'(i));
            stat_word #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_word (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr     (wr_sel[i]),
                .wdata  (reg_wdata),
                .inc_one(inc_one[i]),
                .inc_len(inc_len[i]),
                .len    (fr_len),
                .q      (words[i])
            );
        end
    endgenerate

    // Read mux: selected word, or zero outside the window.
    always_comb begin
        reg_rdata = '0;
        for (int j = 0; j < NUM_WORDS; j++)
            if (in_win && word_idx == ADDR_W'(j)) reg_rdata = words[j];
    end

    // R7: at most one word is selected by a write.
    a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    // R7: a write outside the window selects no word.
    a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr < BASE_A) |-> (wr_sel == '0));

endmodule

// File: tb/tb_stat_counter_bank.sv
module tb_stat_counter_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_done = 1'b0;
    logic        fr_dir = 1'b0;
    logic [15:0] fr_len = '0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [31:0] exp_w [57];

    stat_counter_bank dut (
        .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_dir(fr_dir),
        .fr_len(fr_len), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic string role(input int w);
        if (w == 1 || w == 33 || w == 19 || w == 51) return "R2";
        if (w == 17 || w == 49 || w == 29 || w == 56) return "R3";
        if (w == 7 || w == 39) return "R4";
        if ((w >= 10 && w <= 16) || (w >= 42 && w <= 48)) return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv,
                         input string what);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 57; w++) begin
            reg_addr = 10'(32'h200 + 4 * w);
            #1;
            check(req == "" ? role(w) : req, reg_rdata, exp_w[w], $sformatf("word %0d", w));
        end
    endtask

    function automatic int size_word(input logic rx, input int len);
        int base;
        base = rx ? 32 : 0;
        if (len < 64)        return base + 7;
        else if (len == 64)  return base + 10;
        else if (len < 128)  return base + 11;
        else if (len < 256)  return base + 12;
        else if (len < 512)  return base + 13;
        else if (len < 1024) return base + 14;
        else if (len < 2048) return base + 15;
        return base + 16;
    endfunction

    task automatic model_frame(input logic rx, input int len);
        int base;
        base = rx ? 32 : 0;
        exp_w[base + 1]++;
        exp_w[rx ? 51 : 19]++;
        exp_w[base + 17] += 32'(len);
        exp_w[rx ? 56 : 29] += 32'(len);
        exp_w[size_word(rx, len)]++;
    endtask

    task automatic frame(input logic rx, input int len);
        @(negedge clk);
        fr_done = 1'b1; fr_dir = rx; fr_len = 16'(len);
        @(negedge clk);
        fr_done = 1'b0;
        model_frame(rx, len);
    endtask

    task automatic sw_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        for (int w = 0; w < 57; w++) exp_w[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R4 R5 R2 R3 R6: sweep every length across all bin edges, both sides.
        for (int d = 0; d < 2; d++)
            for (int len = 0; len <= 2100; len++) begin
                frame(d[0], len);
                check_all("");
            end
        frame(1'b0, 65535);
        frame(1'b1, 4096);
        check_all("");

        // R7: outside writes ignored, outside reads zero, low bits ignored.
        sw_write(10'h000, 32'hDEAD_BEEF);
        sw_write(10'h1FC, 32'hDEAD_BEEF);
        sw_write(10'h2E4, 32'hDEAD_BEEF);
        sw_write(10'h3FC, 32'hDEAD_BEEF);
        check_all("R7");
        reg_addr = 10'h2E4; #1; check("R7", reg_rdata, 32'h0, "read 0x2E4");
        reg_addr = 10'h000; #1; check("R7", reg_rdata, 32'h0, "read 0x000");
        reg_addr = 10'h3FF; #1; check("R7", reg_rdata, 32'h0, "read 0x3FF");
        sw_write(10'h203, 32'h1357_9BDF);
        exp_w[0] = 32'h1357_9BDF;
        sw_write(10'h2E2, 32'h0BAD_F00D);
        exp_w[56] = 32'h0BAD_F00D;
        check_all("R7");

        // R8: write and frame hit tx packet word together.
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 10'h204; reg_wdata = 32'h0000_1234;
        fr_done = 1'b1; fr_dir = 1'b0; fr_len = 16'd100;
        @(negedge clk);
        reg_wr = 1'b0; fr_done = 1'b0;
        model_frame(1'b0, 100);
        exp_w[1] = 32'h0000_1234;
        check_all("R8");

        // R9: wrap of unit and length counters.
        sw_write(10'h284, 32'hFFFF_FFFF);
        exp_w[33] = 32'hFFFF_FFFF;
        sw_write(10'h2C4, 32'hFFFF_FFF0);
        exp_w[49] = 32'hFFFF_FFF0;
        sw_write(10'h2E0, 32'hFFFF_FF00);
        exp_w[56] = 32'hFFFF_FF00;
        frame(1'b1, 300);
        check_all("R9");
        reg_addr = 10'h284; #1; check("R9", reg_rdata, 32'h0, "rx packets wrap");
        reg_addr = 10'h2C4; #1; check("R9", reg_rdata, 32'h0000_011C, "rx octets wrap");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule